// File: doc/BRIEF.md
# Dual-Mode Bank and Chip-Select Decoder

This block sits between a host memory controller and four banks of memory. It decodes the host's control inputs into a one-hot set of four bank enables, which steer a shared data bus, and into 32 active-low chip selects grouped as eight per bank. There are two operating modes. In flat mode, one RAM-side enable, a 2-bit bank field and one 3-bit device field pick one of 32 devices. In split mode, the four banks form two pairs that are addressed separately. The lower pair is controlled by the ROM-side enable, bit 0 of the bank field and the B device field. The upper pair is controlled by the RAM-side enable, bit 1 of the bank field and the A device field. The lower pair wins when both pair enables are low.

All decode outputs are registered. When the selection moves from one active target to a different active target, the block first spends one cycle in the all-idle state. Two chip selects are therefore never low together, and two bank paths are never on together. The block also fans the read strobe and the write strobe out to four copies each, one per bank. These copies are passed through whatever the selection is.

Top module: `bank_cs_decoder`

## Requirements
- R1: When romEnN and ramEnN are both high, the next registered state is idle: bankEn is 0000 and every bit of csN is 1.
- R2: In flat mode (modeSplit=0), romEnN has no effect. With ramEnN low, bankSel value k (0 to 3) enables only bankEn[k]. With ramEnN high, the next state is idle.
- R3: Chip-select layout: bank k owns csN[8k+7:8k]. In flat mode, selA value n drives csN[8k+n] low and leaves every other csN bit high.
- R4: In split mode with romEnN low, bankSel[0] selects bank 0 (value 0) or bank 1 (value 1). selB picks the low chip select inside that bank.
- R5: In split mode with romEnN high and ramEnN low, bankSel[1] selects bank 2 (value 0) or bank 3 (value 1). selA picks the low chip select inside that bank.
- R6: In split mode with romEnN low, ramEnN, bankSel[1] and selA have no effect on the outputs.
- R7: At most one bankEn bit is high. csN has exactly as many low bits as bankEn has high bits. A bank's chip-select group contains a low bit only while that bank is enabled.
- R8: A change from one active selection to a different active selection passes through exactly one all-idle cycle. A selection that does not change, including one where only don't-care inputs move, is held with no gap.
- R9: Outputs are registered. From the idle state, a new selection appears after the first rising clock edge that samples it.
- R10: A synchronous active-high rst forces the idle state on the next rising edge.
- R11: rdFan carries four copies of rdStrobe and wrFan carries four copies of wrStrobe, with no clock delay and independent of the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modeSplit | input | 1 | 0 = flat 1-of-4 bank mode, 1 = split pair mode |
| romEnN | input | 1 | Active-low enable for the lower bank pair (split mode only) |
| ramEnN | input | 1 | Active-low enable for all banks (flat mode) or for the upper pair (split mode) |
| bankSel | input | 2 | Bank field |
| selA | input | 3 | Device field A |
| selB | input | 3 | Device field B (lower pair, split mode) |
| rdStrobe | input | 1 | Read strobe to fan out |
| wrStrobe | input | 1 | Write strobe to fan out |
| bankEn | output | 4 | One-hot registered bank path enables |
| csN | output | 32 | Registered active-low chip selects, 8 per bank |
| rdFan | output | 4 | Per-bank copies of rdStrobe |
| wrFan | output | 4 | Per-bank copies of wrStrobe |

## Verification
The hardest case to reach is a selection that changes again while the forced idle cycle is still in progress. The block must then go straight to the newest target and must not insert a second idle cycle. A directed task produces this case by applying three different active selections on three consecutive clocks.

A second subtle case is input motion that changes nothing. Examples are the ROM-side enable toggling in flat mode, or the upper-pair fields moving while the lower pair owns the bus. The bench checks that no idle gap is inserted in these cases.

An exhaustive sweep covers every input combination. It drives each combination for two cycles, starting from whatever state the previous combination left, so that both immediate loads and idle-then-load transitions are exercised.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int NUM_BANKS = 4;

  typedef struct packed {
    logic loadIdle;
    logic loadTarget;
  } seqStrobes_t;
endpackage

// File: rtl/bsd_target_decode.sv
module bsd_target_decode
  import bsd_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int DEVS = 1 << SEL_W,
  localparam int CS_W = NUM_BANKS * DEVS
) (
  input  logic                 modeSplit,
  input  logic                 romEnN,
  input  logic                 ramEnN,
  input  logic [1:0]           bankSel,
  input  logic [SEL_W-1:0]     selA,
  input  logic [SEL_W-1:0]     selB,
  output logic [NUM_BANKS-1:0] tgtBankEn,
  output logic [CS_W-1:0]      tgtCsN
);
  logic             tgtHit;
  logic [1:0]       bankIdx;
  logic [SEL_W-1:0] devIdx;

  always_comb begin
    tgtHit  = 1'b0;
    bankIdx = 2'd0;
    devIdx  = '0;
    if (!modeSplit) begin
      tgtHit  = !ramEnN;
      bankIdx = bankSel;
      devIdx  = selA;
    end else if (!romEnN) begin
      tgtHit  = 1'b1;
      bankIdx = {1'b0, bankSel[0]};
      devIdx  = selB;
    end else if (!ramEnN) begin
      tgtHit  = 1'b1;
      bankIdx = {1'b1, bankSel[1]};
      devIdx  = selA;
    end
  end

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    assign tgtBankEn[k] = tgtHit && (bankIdx == 2'(k));
    assign tgtCsN[k*DEVS +: DEVS] = tgtBankEn[k] ? ~(DEVS'(1) << devIdx) : '1;
  end
endmodule

// File: rtl/bsd_bbm_ctrl.sv
module bsd_bbm_ctrl
  import bsd_pkg::*;
#(
  parameter int CS_W = 32
) (
  input  logic [NUM_BANKS-1:0] tgtBankEn,
  input  logic [CS_W-1:0]      tgtCsN,
  input  logic [NUM_BANKS-1:0] curBankEn,
  input  logic [CS_W-1:0]      curCsN,
  output seqStrobes_t          strobes
);
  logic curActive;
  logic differs;

  always_comb begin
    curActive          = |curBankEn;
    differs            = (tgtBankEn != curBankEn) || (tgtCsN != curCsN);
    strobes.loadIdle   = curActive && differs;
    strobes.loadTarget = !curActive && differs;
  end
endmodule

// File: rtl/bsd_out_regs.sv
module bsd_out_regs
  import bsd_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int DEVS = 1 << SEL_W,
  localparam int CS_W = NUM_BANKS * DEVS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  seqStrobes_t          strobes,
  input  logic [NUM_BANKS-1:0] tgtBankEn,
  input  logic [CS_W-1:0]      tgtCsN,
  output logic [NUM_BANKS-1:0] bankEnQ,
  output logic [CS_W-1:0]      csNQ
);
  always_ff @(posedge clk) begin
    if (rst || strobes.loadIdle) begin
      bankEnQ <= '0;
      csNQ    <= '1;
    end else if (strobes.loadTarget) begin
      bankEnQ <= tgtBankEn;
      csNQ    <= tgtCsN;
    end
  end

  // R7
  one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bankEnQ));

  // R7
  cs_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~csNQ) == $countones(bankEnQ));

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_grp
    // R7
    grp_owner_chk: assert property (@(posedge clk) disable iff (rst)
      bankEnQ[k] == !(&csNQ[k*DEVS +: DEVS]));
  end

  // R8
  break_before_make_chk: assert property (@(posedge clk) disable iff (rst)
    ((|$past(bankEnQ)) && (|bankEnQ)) |-> ($stable(bankEnQ) && $stable(csNQ)));

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (bankEnQ == '0 && &csNQ));
endmodule

// File: rtl/bank_cs_decoder.sv
module bank_cs_decoder
  import bsd_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int DEVS = 1 << SEL_W,
  localparam int CS_W = NUM_BANKS * DEVS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 modeSplit,
  input  logic                 romEnN,
  input  logic                 ramEnN,
  input  logic [1:0]           bankSel,
  input  logic [SEL_W-1:0]     selA,
  input  logic [SEL_W-1:0]     selB,
  input  logic                 rdStrobe,
  input  logic                 wrStrobe,
  output logic [NUM_BANKS-1:0] bankEn,
  output logic [CS_W-1:0]      csN,
  output logic [NUM_BANKS-1:0] rdFan,
  output logic [NUM_BANKS-1:0] wrFan
);
  logic [NUM_BANKS-1:0] tgtBankEn;
  logic [CS_W-1:0]      tgtCsN;
  seqStrobes_t          strobes;

  bsd_target_decode #(.SEL_W(SEL_W)) u_decode (
    .modeSplit(modeSplit), .romEnN(romEnN), .ramEnN(ramEnN),
    .bankSel(bankSel), .selA(selA), .selB(selB),
    .tgtBankEn(tgtBankEn), .tgtCsN(tgtCsN)
  );

  bsd_bbm_ctrl #(.CS_W(CS_W)) u_ctrl (
    .tgtBankEn(tgtBankEn), .tgtCsN(tgtCsN),
    .curBankEn(bankEn), .curCsN(csN),
    .strobes(strobes)
  );

  bsd_out_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .strobes(strobes),
    .tgtBankEn(tgtBankEn), .tgtCsN(tgtCsN),
    .bankEnQ(bankEn), .csNQ(csN)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_fan
    assign rdFan[i] = rdStrobe;
    assign wrFan[i] = wrStrobe;
  end
endmodule

// File: tb/tb_bank_cs_decoder.sv
module tb_bank_cs_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic modeSplit = 1'b0, romEnN = 1'b1, ramEnN = 1'b1;
  logic [1:0] bankSel = '0;
  logic [2:0] selA = '0, selB = '0;
  logic rdStrobe = 1'b0, wrStrobe = 1'b0;
  logic [3:0] bankEn, rdFan, wrFan;
  logic [31:0] csN;

  int checks = 0;
  int fails = 0;
  logic [3:0]  expBank = '0;
  logic [31:0] expCs = '1;

  always #2 clk = ~clk;

  bank_cs_decoder dut (
    .clk(clk), .rst(rst), .modeSplit(modeSplit), .romEnN(romEnN), .ramEnN(ramEnN),
    .bankSel(bankSel), .selA(selA), .selB(selB), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .bankEn(bankEn), .csN(csN), .rdFan(rdFan), .wrFan(wrFan)
  );

  // Reference target from the requirements R1-related rules (R2..R6 below)
  task automatic refTarget(output logic [3:0] tb, output logic [31:0] tc);
    logic hit; logic [1:0] bk; logic [2:0] dv;
    hit = 1'b0; bk = 2'd0; dv = 3'd0;
    if (!modeSplit) begin hit = !ramEnN; bk = bankSel; dv = selA; end       // R2 R3
    else if (!romEnN) begin hit = 1'b1; bk = {1'b0, bankSel[0]}; dv = selB; end // R4 R6
    else if (!ramEnN) begin hit = 1'b1; bk = {1'b1, bankSel[1]}; dv = selA; end // R5
    tb = hit ? (4'b1 << bk) : 4'b0;
    tc = hit ? ~(32'b1 << (bk * 8 + dv)) : '1;
  endtask

  task automatic check(input string req, input logic [3:0] eb, input logic [31:0] ec);
    checks++;
    if (bankEn !== eb || csN !== ec) begin
      fails++;
      $display("FAIL %s: bankEn=%b csN=%h expected bankEn=%b csN=%h", req, bankEn, csN, eb, ec);
    end
  endtask

  // Apply current inputs for one clock, advance model, check at the following negedge (R8 R9)
  task automatic stepCheck(input string req);
    logic [3:0] tb; logic [31:0] tc;
    refTarget(tb, tc);
    if (tb != expBank || tc != expCs) begin
      if (|expBank) begin expBank = '0; expCs = '1; end
      else begin expBank = tb; expCs = tc; end
    end
    @(negedge clk);
    check(req, expBank, expCs);
  endtask

  task automatic drive(input logic m, input logic ro, input logic ra,
                       input logic [1:0] bk, input logic [2:0] a, input logic [2:0] b);
    modeSplit = m; romEnN = ro; ramEnN = ra; bankSel = bk; selA = a; selB = b;
  endtask

  task automatic testReset();
    drive(0, 0, 0, 2'd1, 3'd2, 3'd0);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset", 4'b0, '1);
    rst = 1'b0; expBank = '0; expCs = '1;
    stepCheck("R9 first load");
    check("R9 explicit", 4'b0010, ~(32'b1 << 10));
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid-run reset", 4'b0, '1);
    rst = 1'b0; expBank = '0; expCs = '1;
    drive(0, 1, 1, 0, 0, 0);
    stepCheck("R1 idle");
  endtask

  task automatic testModes();
    drive(0, 1, 0, 2'd3, 3'd7, 3'd0); stepCheck("R2 R3 bank3 dev7");
    check("R3 explicit", 4'b1000, ~(32'b1 << 31));
    romEnN = 0; selB = 3'd5; stepCheck("R2 rom ignored, no gap");
    check("R2 hold", 4'b1000, ~(32'b1 << 31));
    drive(1, 0, 0, 2'd1, 3'd4, 3'd6); stepCheck("R8 idle cycle");
    check("R8 explicit idle", 4'b0, '1);
    stepCheck("R4 bank1 selB");
    check("R4 explicit", 4'b0010, ~(32'b1 << 14));
    ramEnN = 1; bankSel = 2'd3; selA = 3'd1; stepCheck("R6 don't-care");
    check("R6 hold", 4'b0010, ~(32'b1 << 14));
    drive(1, 1, 0, 2'd2, 3'd3, 3'd0); stepCheck("R8 idle");
    stepCheck("R5 bank3 selA");
    check("R5 explicit", 4'b1000, ~(32'b1 << 27));
    drive(1, 1, 1, 0, 0, 0); stepCheck("R1 release");
    check("R1 explicit", 4'b0, '1);
  endtask

  task automatic testRapidChange();
    drive(0, 1, 0, 2'd0, 3'd1, 3'd0); stepCheck("R9 load A");
    drive(0, 1, 0, 2'd1, 3'd1, 3'd0); stepCheck("R8 idle after A");
    drive(0, 1, 0, 2'd2, 3'd6, 3'd0); stepCheck("R8 direct to C");
    check("R8 explicit C", 4'b0100, ~(32'b1 << 22));
  endtask

  task automatic testSweep();
    for (int v = 0; v < 2048; v++) begin
      drive(v[10], v[9], v[8], v[7:6], v[5:3], v[2:0]);
      stepCheck("R7 sweep c1");
      stepCheck("R7 sweep c2");
    end
  endtask

  task automatic testFanout();
    for (int s = 0; s < 4; s++) begin
      rdStrobe = s[0]; wrStrobe = s[1];
      #1;
      checks++;
      if (rdFan !== {4{s[0]}} || wrFan !== {4{s[1]}}) begin
        fails++;
        $display("FAIL R11: rdFan=%b wrFan=%b expected %b %b", rdFan, wrFan, {4{s[0]}}, {4{s[1]}});
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testModes();
    testRapidChange();
    testFanout();
    testSweep();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule